// File: doc/BRIEF.md
# Two-Deep Receive Buffer with Per-Character Status

This block sits between a serial frame receiver and a register-style read port. Each finished character arrives as a one-cycle strobe carrying its raw bits, the level of its first stop bit and a parity-mismatch indication. The block packs these into an entry that holds the character bits, the ninth bit, a frame-error bit, a parity-error bit and an overrun bit. It then queues the entry in a two-entry FIFO. The status and the ninth bit on the read side always belong to the entry at the head, so a reader has to sample them before it pops the data.

When both FIFO slots are taken, one more completed character can wait in a holding stage that plays the role of the shift register. A start-bit event that arrives while the FIFO is full and the holding stage is occupied counts as an overrun. The newly arriving frame is then thrown away, and the held character is marked as overrun when it moves into the FIFO. The block drives a receive-complete flag and a level interrupt request, and clearing the enable empties everything.

Top module: `rxbuf_status`

## Requirements
- R1: After reset the FIFO is empty: `rx_cplt`, `rx_irq` and all head outputs (`rd_data`, `rd_bit9`, `st_frame_err`, `st_par_err`, `st_overrun`) are 0.
- R2: Characters are read out in arrival order, and `rx_cplt` is 1 exactly while at least one unread entry exists.
- R3: Status is stored per entry. A pulse on `rd_pop` while entries exist removes the head, and the status outputs then show the next entry's own status.
- R4: `st_par_err` of an entry is 1 only if `par_chk_en` was 1 when that frame was captured and `frm_par_bad` was 1.
- R5: `char_size` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and codes 4 to 7 select 9 bits. Character bits above the selected size read as 0. `rd_bit9` equals raw bit 8 only in 9-bit mode and is 0 otherwise.
- R6: A frame that completes while the FIFO holds two entries waits in the holding stage. It enters the FIFO after a pop, keeping its order behind the earlier entries.
- R7: Overrun occurs when `start_det` pulses while the FIFO is full and the holding stage is occupied. Any frame completing while the holding stage is still occupied is discarded. The held character reaches the FIFO with `st_overrun` = 1, and later entries carry `st_overrun` = 0.
- R8: `rx_irq` is 1 exactly when `rx_cplt` and `rxc_ie` are both 1.
- R9: While `rx_en` is 0, the FIFO, the holding stage and any pending overrun are cleared. `rx_cplt` is 0 one cycle later, and completed frames are ignored.
- R10: A `rd_pop` while the FIFO is empty leaves the pointers unchanged. The head outputs keep showing the entry that was last popped.
- R11: `st_frame_err` of an entry is 1 exactly when `frm_stop_ok` was 0 for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receiver enable; 0 flushes |
| char_size | input | 3 | Character size code (see R5) |
| par_chk_en | input | 1 | Parity checking enabled |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| frm_valid | input | 1 | One-cycle strobe: a frame finished its first stop bit |
| frm_data | input | 9 | Raw received bits, bit 0 first received |
| frm_stop_ok | input | 1 | First stop bit was sampled as 1 |
| frm_par_bad | input | 1 | Parity mismatch on this frame |
| start_det | input | 1 | One-cycle strobe: a new start bit was detected |
| rd_pop | input | 1 | Read of the data location; pops the head |
| rd_data | output | 8 | Head character bits |
| rd_bit9 | output | 1 | Head ninth bit |
| st_frame_err | output | 1 | Head frame error |
| st_par_err | output | 1 | Head parity error |
| st_overrun | output | 1 | Head overrun mark |
| rx_cplt | output | 1 | Unread data present |
| rx_irq | output | 1 | Level interrupt request |

## Verification
The bench aims at the third character that waits while the FIFO is full. A design that dropped this character, or let it overtake an earlier one, would show a gap or a swapped value at the read side. It also fires a start bit into the full state and then sends a frame. A design that kept the new frame would leave an extra entry behind. A design that marked the wrong entry, or never cleared the overrun mark, would show `st_overrun` on the wrong character.

Other cases the bench checks are these. Status is compared with each entry's own frame, so flags that belonged to the block as a whole instead of to each entry would mismatch. Short and nine-bit sizes confirm that the masking and the ninth-bit rule apply. A read on an empty FIFO followed by a new frame shows whether the pointers slipped. A frame that arrives while the receiver is disabled must leave `rx_cplt` low.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned SIZE_W = 3;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              bit9;
    logic              ferr;
    logic              perr;
    logic              ovr;
  } rxb_entry_t;

  // keep-mask of the character bits for a size code; 9-bit codes keep all 8
  function automatic logic [CHAR_W-1:0] size_mask(input logic [SIZE_W-1:0] sz);
    logic [CHAR_W-1:0] m;
    case (sz)
      3'd0:    m = 8'h1F;
      3'd1:    m = 8'h3F;
      3'd2:    m = 8'h7F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rxb_frame_pack.sv
module rxb_frame_pack
  import rxb_pkg::*;
(
  input  logic [CHAR_W:0]   raw,
  input  logic              stop_ok,
  input  logic              par_bad,
  input  logic              chk_en,
  input  logic [SIZE_W-1:0] csize,
  output rxb_entry_t        ent
);
  always_comb begin
    ent.data = raw[CHAR_W-1:0] & size_mask(csize);
    ent.bit9 = csize[SIZE_W-1] & raw[CHAR_W];   // R5: codes 4..7 are 9-bit
    ent.ferr = ~stop_ok;                        // R11
    ent.perr = par_bad & chk_en;                // R4
    ent.ovr  = 1'b0;
  end
endmodule

// File: rtl/rxb_hold_stage.sv
module rxb_hold_stage
  import rxb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       in_valid,
  input  rxb_entry_t in_ent,
  input  logic       start_det,
  input  logic       fifo_full,
  output logic       push,
  output rxb_entry_t push_ent
);
  logic       hold_v_q, hold_v_d;
  rxb_entry_t hold_e_q, hold_e_d;
  logic       ovr_q, ovr_d;
  rxb_entry_t held_out;

  always_comb begin
    held_out     = hold_e_q;
    held_out.ovr = ovr_q;
    push         = enable & ~fifo_full & (hold_v_q | in_valid);
    push_ent     = hold_v_q ? held_out : in_ent;
  end

  always_comb begin
    hold_v_d = hold_v_q;
    hold_e_d = hold_e_q;
    ovr_d    = ovr_q;
    if (!enable) begin
      hold_v_d = 1'b0;
      ovr_d    = 1'b0;
    end else if (hold_v_q) begin
      if (!fifo_full) begin
        // held character moves in; a frame finishing now takes its place
        hold_v_d = in_valid;
        hold_e_d = in_ent;
        ovr_d    = 1'b0;
      end else if (start_det) begin
        ovr_d = 1'b1;                 // R7: full + parked + new start bit
      end
    end else if (in_valid && fifo_full) begin
      hold_v_d = 1'b1;                // R6: park third character
      hold_e_d = in_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_e_q <= '0;
      ovr_q    <= 1'b0;
    end else begin
      hold_v_q <= hold_v_d;
      ovr_q    <= ovr_d;
      if (hold_v_d != hold_v_q || hold_v_d) hold_e_q <= hold_e_d;
    end
  end

  a_r7_overrun_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hold_v_q && fifo_full && start_det) |=> ovr_q);
  a_r7_overrun_needs_parked: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> hold_v_q);
  a_r9_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hold_v_q && !ovr_q));
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo
  import rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  rxb_entry_t push_ent,
  input  logic       pop,
  output rxb_entry_t head,
  output logic       empty,
  output logic       full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  rxb_entry_t       slot_q [DEPTH];
  rxb_entry_t       last_q, last_d;
  logic             pop_ok, wr_en;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok = pop & ~empty & ~flush;
  assign wr_en  = push & ~flush;
  assign head   = empty ? last_q : slot_q[rd_q];

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_en) wr_d = bump(wr_q);
      if (pop_ok) begin
        rd_d   = bump(rd_q);
        last_d = slot_q[rd_q];        // R10: remembered for empty reads
      end
      cnt_d = cnt_q + CNT_W'(wr_en) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      if (pop_ok) last_q <= last_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot_q[i] <= '0;
      else if (wr_en && wr_q == PTR_W'(i))    slot_q[i] <= push_ent;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r10_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !flush && !push) |=> ($stable(rd_q) && $stable(wr_q) && empty));
endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status
  import rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic [SIZE_W-1:0]   char_size,
  input  logic                par_chk_en,
  input  logic                rxc_ie,
  input  logic                frm_valid,
  input  logic [CHAR_W:0]     frm_data,
  input  logic                frm_stop_ok,
  input  logic                frm_par_bad,
  input  logic                start_det,
  input  logic                rd_pop,
  output logic [CHAR_W-1:0]   rd_data,
  output logic                rd_bit9,
  output logic                st_frame_err,
  output logic                st_par_err,
  output logic                st_overrun,
  output logic                rx_cplt,
  output logic                rx_irq
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  rxb_entry_t cap_ent, push_ent, head;
  logic       push, fifo_empty, fifo_full;

  rxb_frame_pack u_pack (
    .raw     (frm_data),
    .stop_ok (frm_stop_ok),
    .par_bad (frm_par_bad),
    .chk_en  (par_chk_en),
    .csize   (char_size),
    .ent     (cap_ent)
  );

  rxb_hold_stage u_hold (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .enable    (rx_en),
    .in_valid  (frm_valid),
    .in_ent    (cap_ent),
    .start_det (start_det),
    .fifo_full (fifo_full),
    .push      (push),
    .push_ent  (push_ent)
  );

  rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .flush    (~rx_en),
    .push     (push),
    .push_ent (push_ent),
    .pop      (rd_pop),
    .head     (head),
    .empty    (fifo_empty),
    .full     (fifo_full)
  );

  assign rd_data      = head.data;
  assign rd_bit9      = head.bit9;
  assign st_frame_err = head.ferr;
  assign st_par_err   = head.perr;
  assign st_overrun   = head.ovr;
  assign rx_cplt      = ~fifo_empty;
  assign rx_irq       = rx_cplt & rxc_ie;

  a_r8_irq_needs_data: assert property (@(posedge clk) disable iff (!core_rst_n)
    rx_irq |-> (rx_cplt && rxc_ie));
  a_r9_flush_clears_flag: assert property (@(posedge clk) disable iff (!core_rst_n)
    !rx_en |=> !rx_cplt);
  a_r2_push_sets_flag: assert property (@(posedge clk) disable iff (!core_rst_n)
    (push && rx_en) |=> rx_cplt);
endmodule

// File: tb/rxbuf_status_test.sv
module rxbuf_status_test;
  typedef struct packed {
    logic [7:0] data;
    logic       b9;
    logic       fe;
    logic       pe;
    logic       ov;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en, par_chk_en, rxc_ie, frm_valid, frm_stop_ok, frm_par_bad;
  logic       start_det, rd_pop;
  logic [2:0] char_size;
  logic [8:0] frm_data;
  logic [7:0] rd_data;
  logic       rd_bit9, st_frame_err, st_par_err, st_overrun, rx_cplt, rx_irq;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  rxbuf_status uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .char_size(char_size),
    .par_chk_en(par_chk_en), .rxc_ie(rxc_ie), .frm_valid(frm_valid),
    .frm_data(frm_data), .frm_stop_ok(frm_stop_ok), .frm_par_bad(frm_par_bad),
    .start_det(start_det), .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .st_frame_err(st_frame_err), .st_par_err(st_par_err), .st_overrun(st_overrun),
    .rx_cplt(rx_cplt), .rx_irq(rx_irq)
  );

  function automatic logic [7:0] keep_bits(input logic [2:0] sz);
    if (sz >= 3'd3) return 8'hFF;
    return 8'((16'd1 << (5 + sz)) - 16'd1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: deliver one finished frame; queue the expected entry if kept
  task automatic send(input logic [8:0] raw, input logic stop_ok, input logic pbad,
                      input bit kept);
    exp_t e;
    @(negedge clk);
    frm_valid = 1'b1; frm_data = raw; frm_stop_ok = stop_ok; frm_par_bad = pbad;
    @(negedge clk);
    frm_valid = 1'b0;
    if (kept) begin
      e.data = raw[7:0] & keep_bits(char_size);
      e.b9   = (char_size >= 3'd4) ? raw[8] : 1'b0;
      e.fe   = ~stop_ok;
      e.pe   = pbad & par_chk_en;
      e.ov   = 1'b0;
      sb_q.push_back(e);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  // monitor: compare head against scoreboard, then pop
  task automatic pop_check(input string req);
    exp_t e;
    @(negedge clk);
    e = sb_q.pop_front();
    check({req, " data"},   32'(rd_data),      32'(e.data));
    check({req, " bit9"},   32'(rd_bit9),      32'(e.b9));
    check({req, " ferr"},   32'(st_frame_err), 32'(e.fe));
    check({req, " perr"},   32'(st_par_err),   32'(e.pe));
    check({req, " ovr"},    32'(st_overrun),   32'(e.ov));
    check({req, " cplt"},   32'(rx_cplt),      32'd1);
    rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] keep_d;
    logic       keep_f, keep_p;
    rst_n = 1'b0; rx_en = 1'b1; char_size = 3'd3; par_chk_en = 1'b1; rxc_ie = 1'b1;
    frm_valid = 1'b0; frm_data = '0; frm_stop_ok = 1'b1; frm_par_bad = 1'b0;
    start_det = 1'b0; rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 cplt", 32'(rx_cplt), 0);
    check("R1 irq",  32'(rx_irq), 0);
    check("R1 head", 32'({rd_data, rd_bit9, st_frame_err, st_par_err, st_overrun}), 0);

    // R2 R3 R6 R11 R4: order, per-entry status, third parked
    send(9'h0A5, 1'b1, 1'b0, 1'b1);
    check("R8 irq with data", 32'(rx_irq), 1);
    rxc_ie = 1'b0; @(negedge clk);
    check("R8 irq masked", 32'(rx_irq), 0);
    rxc_ie = 1'b1;
    send(9'h03C, 1'b0, 1'b0, 1'b1);
    send(9'h07E, 1'b1, 1'b1, 1'b1);
    pop_check("R11 R2 first");
    pop_check("R11 R3 second");
    pop_check("R6 R4 parked third");
    @(negedge clk);
    check("R2 empty cplt", 32'(rx_cplt), 0);
    check("R8 empty irq", 32'(rx_irq), 0);

    // R10 read on empty
    keep_d = rd_data; keep_f = st_frame_err; keep_p = st_par_err;
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; @(negedge clk);
    check("R10 data held", 32'(rd_data), 32'(keep_d));
    check("R10 perr held", 32'({keep_f, st_par_err}), 32'({st_frame_err, keep_p}));
    check("R10 still empty", 32'(rx_cplt), 0);
    send(9'h155, 1'b1, 1'b0, 1'b1);
    pop_check("R10 pointers intact");

    // R4 parity checking off
    par_chk_en = 1'b0;
    send(9'h011, 1'b1, 1'b1, 1'b1);
    pop_check("R4 check disabled");
    par_chk_en = 1'b1;

    // R5 sizes
    char_size = 3'd0; send(9'h1FF, 1'b1, 1'b0, 1'b1); pop_check("R5 five bits");
    char_size = 3'd2; send(9'h1FF, 1'b1, 1'b0, 1'b1); pop_check("R5 seven bits");
    char_size = 3'd4; send(9'h1AB, 1'b1, 1'b0, 1'b1); pop_check("R5 nine bits");
    char_size = 3'd6; send(9'h0CD, 1'b1, 1'b0, 1'b1); pop_check("R5 nine bits low");
    char_size = 3'd3;

    // R7 overrun
    send(9'h011, 1'b1, 1'b0, 1'b1);
    send(9'h022, 1'b1, 1'b0, 1'b1);
    pulse_start();                           // full but nothing parked: no overrun
    send(9'h033, 1'b1, 1'b0, 1'b1);
    pulse_start();                           // full + parked: overrun
    send(9'h044, 1'b1, 1'b0, 1'b0);          // discarded
    sb_q[$].ov = 1'b1;
    pop_check("R7 before overrun a");
    pop_check("R7 before overrun b");
    pop_check("R7 marked entry");
    @(negedge clk);
    check("R7 dropped frame absent", 32'(rx_cplt), 0);
    send(9'h055, 1'b1, 1'b0, 1'b1);
    pop_check("R7 mark cleared");

    // R9 flush
    send(9'h066, 1'b1, 1'b0, 1'b1);
    send(9'h077, 1'b1, 1'b0, 1'b1);
    send(9'h088, 1'b1, 1'b0, 1'b1);
    pulse_start();
    rx_en = 1'b0; @(negedge clk);
    check("R9 flushed", 32'(rx_cplt), 0);
    send(9'h099, 1'b1, 1'b0, 1'b0);
    rx_en = 1'b1; @(negedge clk); @(negedge clk);
    check("R9 ignored while off", 32'(rx_cplt), 0);
    sb_q.delete();
    send(9'h0AA, 1'b1, 1'b0, 1'b1);
    pop_check("R9 after re-enable");
    @(negedge clk);
    check("R9 parked lost", 32'(rx_cplt), 0);

    done = 1'b1;
    finish_run();
  end
endmodule